// File: doc/BRIEF.md
# Converter Serial Frame Responder with Offset Calibration

This block is the digital face of a 12-bit sampling converter. A host frames each transaction by pulling chip select low and then toggling the serial clock. The block answers on a single data output. It drives two leading zeros, then the 12-bit result MSB first, and then holds the line low. It releases the line when chip select returns high. Both chip select and the serial clock are asynchronous to the block. They are brought into the system clock domain through synchronisers and then edge-detected. The system clock must run at least four times faster than the serial clock.

The raw conversion word arrives on a parallel input and is captured once, at frame start. A calibration value arrives on another parallel input. The block copies it into a private signed offset register only when a frame carries enough serial clocks. The first frame after reset is always a calibration frame, and the data line stays low for all of it. In that frame, 16 clocks are enough to commit. In any later frame, 32 clocks are needed, and the commit happens on the 32nd falling edge. Every result is reduced by the stored offset and clamped to the code range before it is shifted. No port applies back-pressure. Both parallel inputs are plain levels sampled at defined instants, so there is no valid/ready handshake.

Top module: `adc_frame_responder`

## Requirements
- R1: While no frame is open, `sdo_oe_o` is 0, which stands for high impedance. A chip-select falling edge sets it to 1 within 5 system clocks, and a rising edge clears it within 5 system clocks.
- R2: After frame start and before any serial-clock falling edge, `sdo_o` is 0. After the 1st falling edge it is 0 again. After falling edge k, for k from 2 to 13, it carries result bit 13-k, so the MSB comes first.
- R3: From the 14th serial-clock falling edge until chip select rises, `sdo_o` is 0.
- R4: In the first frame after reset, `sdo_o` is 0 for the whole frame.
- R5: In the first frame after reset, the 16th serial-clock falling edge loads `cal_i` into the offset register. If that frame ends with fewer than 16 falling edges, the register is left unchanged. Either way, the next frame is a normal frame.
- R6: In a normal frame, the 32nd serial-clock falling edge loads `cal_i` into the offset register. A normal frame with fewer than 32 falling edges leaves the register unchanged.
- R7: Reset clears the offset register to zero and makes the next frame a calibration frame.
- R8: The shifted result is the unsigned `sample_i` minus the offset, where the offset is read as 12-bit two's complement. The result is clamped to the range 0x000 to 0xFFF, where 0x000 is negative full scale, 0x800 is mid code and 0xFFF is positive full scale.
- R9: `sample_i` is sampled only at frame start. Changing it during a frame does not affect the bits shifted in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low power-up reset |
| cs_n_i | input | 1 | Asynchronous chip select, active low |
| sclk_i | input | 1 | Asynchronous serial clock |
| sample_i | input | DATA_W | Raw conversion word |
| cal_i | input | DATA_W | Calibration value, two's complement |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Data output enable; 0 means high impedance |

## Verification
Some properties are checked on every cycle by assertions:
- the output is enabled exactly while a frame is open;
- the data line is low throughout a calibration frame and in the tail after 14 clocks;
- the offset register changes only on a commit, and a commit loads the value present on `cal_i`;
- a commit fires only on the 16th edge of a calibration frame or the 32nd edge of a normal one.

Other behaviour can only be shown by the bench's scenarios: the exact bit order, the subtraction with clamping at both ends, the threshold frames of 15/16 and 31/32 clocks, the effect of reset on the offset, and the insensitivity to `sample_i` changing mid-frame.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_CAL  = 2'd1,
    FR_DATA = 2'd2
  } sfr_frame_e;
endpackage

// File: rtl/sfr_sync_edge.sv
module sfr_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
  import sfr_pkg::*;
#(
  parameter int PWR_CLKS = 16,
  parameter int RUN_CLKS = 32,
  parameter int CNT_W    = $clog2(RUN_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_fall,
  output sfr_frame_e       kind,
  output logic [CNT_W-1:0] fall_cnt,
  output logic             first_pending,
  output logic             commit
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RUN_CLKS);
  localparam logic [CNT_W-1:0] PWR_LAST = CNT_W'(PWR_CLKS - 1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_CLKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind          <= FR_IDLE;
      fall_cnt      <= '0;
      first_pending <= 1'b1;
    end else if (cs_rise) begin
      kind <= FR_IDLE;
      if (kind == FR_CAL) first_pending <= 1'b0;
    end else if (cs_fall) begin
      kind     <= first_pending ? FR_CAL : FR_DATA;
      fall_cnt <= '0;
    end else if (sck_fall && kind != FR_IDLE && fall_cnt != CNT_MAX) begin
      fall_cnt <= fall_cnt + 1'b1;
    end
  end

  always_comb begin
    commit = 1'b0;
    if (sck_fall && !cs_rise) begin
      if (kind == FR_CAL  && fall_cnt == PWR_LAST) commit = 1'b1;
      if (kind == FR_DATA && fall_cnt == RUN_LAST) commit = 1'b1;
    end
  end
endmodule

// File: rtl/sfr_offset_reg.sv
module sfr_offset_reg #(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [OFS_W-1:0] cal,
  output logic [OFS_W-1:0] ofs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ofs <= '0;
    else if (commit) ofs <= cal;
  end
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int DATA_W = 12,
  parameter int OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_fall,
  input  logic              cal_frame,
  input  logic [DATA_W-1:0] sample,
  input  logic [OFS_W-1:0]  ofs,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int DW   = DATA_W + 2;
  localparam int SH_W = DATA_W + 2;

  logic signed [DW-1:0] s_ext, o_ext, diff;
  logic [DATA_W-1:0]    corr;
  logic [SH_W-1:0]      shreg;

  always_comb begin
    s_ext = $signed({2'b00, sample});
    o_ext = $signed({{(DW-OFS_W){ofs[OFS_W-1]}}, ofs});
    diff  = s_ext - o_ext;
    if (diff[DW-1])                  corr = '0;
    else if (diff[DW-2:DATA_W] != 0) corr = '1;
    else                             corr = diff[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sdo_oe <= 1'b0;
    end else if (cs_rise) begin
      shreg  <= '0;
      sdo_oe <= 1'b0;
    end else if (cs_fall) begin
      shreg  <= cal_frame ? '0 : {2'b00, corr};
      sdo_oe <= 1'b1;
    end else if (sck_fall && sdo_oe) begin
      shreg  <= {shreg[SH_W-2:0], 1'b0};
    end
  end

  assign sdo = shreg[SH_W-1];
endmodule

// File: rtl/adc_frame_responder.sv
module adc_frame_responder
  import sfr_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int PWR_CLKS    = 16,
  parameter int RUN_CLKS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] cal_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int CNT_W = $clog2(RUN_CLKS + 1);

  logic cs_lvl, cs_rise, cs_fall;
  logic sck_lvl, sck_rise, sck_fall;
  sfr_frame_e        frame_kind;
  logic [CNT_W-1:0]  fall_cnt;
  logic              first_pending;
  logic              commit;
  logic [DATA_W-1:0] ofs_q;

  sfr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n_i),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));

  sfr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk_i),
    .level(sck_lvl), .rise(sck_rise), .fall(sck_fall));

  sfr_frame_ctrl #(.PWR_CLKS(PWR_CLKS), .RUN_CLKS(RUN_CLKS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_fall(sck_fall), .kind(frame_kind), .fall_cnt(fall_cnt),
    .first_pending(first_pending), .commit(commit));

  sfr_offset_reg #(.OFS_W(DATA_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cal(cal_i), .ofs(ofs_q));

  sfr_shifter #(.DATA_W(DATA_W), .OFS_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_fall(sck_fall), .cal_frame(first_pending), .sample(sample_i),
    .ofs(ofs_q), .sdo(sdo_o), .sdo_oe(sdo_oe_o));

  logic unused_lvl;
  assign unused_lvl = cs_lvl ^ sck_lvl ^ sck_rise;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
  import sfr_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int PWR_CLKS = 16,
  parameter int RUN_CLKS = 32,
  parameter int CNT_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input sfr_frame_e        frame_kind,
  input logic [CNT_W-1:0]  fall_cnt,
  input logic              commit,
  input logic [DATA_W-1:0] cal_i,
  input logic [DATA_W-1:0] ofs_q
);
  AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_kind == FR_IDLE |-> !sdo_oe_o); // R1
  AST_DRIVE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_kind != FR_IDLE |-> sdo_oe_o); // R1
  AST_CAL_FRAME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_kind == FR_CAL |-> !sdo_o); // R4
  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_kind == FR_DATA && fall_cnt >= CNT_W'(14)) |-> !sdo_o); // R3
  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ofs_q)); // R6
  AST_OFS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ofs_q == $past(cal_i)); // R5
  AST_COMMIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ((frame_kind == FR_CAL && fall_cnt == CNT_W'(PWR_CLKS - 1)) ||
                (frame_kind == FR_DATA && fall_cnt == CNT_W'(RUN_CLKS - 1)))); // R6
endmodule

bind adc_frame_responder sfr_checker #(
  .DATA_W(DATA_W), .PWR_CLKS(PWR_CLKS), .RUN_CLKS(RUN_CLKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .frame_kind(frame_kind), .fall_cnt(fall_cnt), .commit(commit),
  .cal_i(cal_i), .ofs_q(ofs_q));

// File: tb/adc_frame_responder_tb.sv
module adc_frame_responder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [11:0] sample_i = '0;
  logic [11:0] cal_i = '0;
  logic sdo, sdo_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [11:0] m_ofs;
  bit m_first;

  always #4 clk = ~clk;

  adc_frame_responder u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
    .sample_i(sample_i), .cal_i(cal_i), .sdo_o(sdo), .sdo_oe_o(sdo_oe));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] exp_word(logic [11:0] smp, logic [11:0] ofs);
    int o = ofs[11] ? int'(ofs) - 4096 : int'(ofs);
    int v = int'(smp) - o;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v[11:0];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b0;
    wait_clks(4);
    check("R1 oe in reset", int'(sdo_oe), 0);
    rst_n = 1'b1;
    m_ofs = '0;
    m_first = 1'b1;
    wait_clks(3);
  endtask

  // one frame with n serial clocks; tag names the requirement for the word check
  task automatic run_frame(int n, logic [11:0] smp, logic [11:0] cal,
                           bit chg_mid, string tag);
    logic [11:0] w = exp_word(smp, m_ofs);
    logic [11:0] rx = '0;
    bit first = m_first;
    @(negedge clk);
    sample_i = smp;
    cal_i = cal;
    cs_n = 1'b0;
    wait_clks(5);
    check("R1 oe at frame start", int'(sdo_oe), 1);
    check(first ? "R4 first bit" : "R2 first zero", int'(sdo), 0);
    for (int k = 1; k <= n; k++) begin
      sclk = 1'b1;
      wait_clks(4);
      sclk = 1'b0;
      wait_clks(5);
      if (chg_mid && k == 1) sample_i = ~smp;
      if (first)        check("R4 cal frame low", int'(sdo), 0);
      else if (k == 1)  check("R2 second zero", int'(sdo), 0);
      else if (k <= 13) begin
        rx[13-k] = sdo;
        check("R2 data bit", int'(sdo), int'(w[13-k]));
      end else          check("R3 tail low", int'(sdo), 0);
    end
    if (!first && n >= 13) check(tag, int'(rx), int'(w));
    @(negedge clk);
    cs_n = 1'b1;
    wait_clks(5);
    check("R1 oe after frame", int'(sdo_oe), 0);
    if (first && n >= 16) m_ofs = cal;
    if (!first && n >= 32) m_ofs = cal;
    m_first = 1'b0;
    wait_clks(3);
  endtask

  initial begin
    void'($urandom(32'h5EED_0043));
    do_reset();
    // R5: short calibration frame, no commit
    run_frame(10, 12'h123, 12'h010, 0, "R5");
    run_frame(14, 12'h123, 12'h000, 0, "R5 no commit below 16");
    // R7: reset returns to calibration frame and zero offset
    run_frame(32, 12'h400, 12'h040, 0, "R6 32 clk");
    run_frame(14, 12'h400, 12'h000, 0, "R6 commit at 32");
    do_reset();
    run_frame(16, 12'h300, 12'h020, 0, "R4");
    run_frame(14, 12'h300, 12'h000, 0, "R5 commit at 16");
    // R6: 31 clocks keep, 32 clocks commit
    run_frame(31, 12'h300, 12'h050, 0, "R6 31 clk");
    run_frame(14, 12'h300, 12'h050, 0, "R6 no commit below 32");
    run_frame(32, 12'h300, 12'h050, 0, "R6 32 clk");
    run_frame(20, 12'h300, 12'h050, 0, "R6 commit seen");
    do_reset();
    run_frame(16, 12'h7FF, 12'h000, 0, "R4");
    run_frame(14, 12'h7FF, 12'h000, 0, "R7 zero offset after reset");
    // R8: clamping at both ends and code extremes
    run_frame(32, 12'h000, 12'h100, 0, "R8");
    run_frame(14, 12'h050, 12'h100, 0, "R8 clamp low");
    run_frame(32, 12'h800, 12'hF00, 0, "R8");
    run_frame(14, 12'hF80, 12'hF00, 0, "R8 clamp high");
    run_frame(14, 12'h800, 12'hF00, 0, "R8 mid plus offset");
    // R9: sample changes mid frame
    run_frame(14, 12'hA5C, 12'h000, 1, "R9 sample held");
    for (int i = 0; i < 40; i++) begin
      int r = int'($urandom_range(0, 511)) - 256;
      int sel = int'($urandom_range(0, 3));
      int n = (sel == 0) ? 14 : (sel == 1) ? 20 : (sel == 2) ? 32 : 40;
      run_frame(n, 12'($urandom_range(0, 4095)), r[11:0], 0, "R8 random");
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule